// File: doc/BRIEF.md
# Keyed Watchdog Timer

This block is a watchdog that counts on its own oscillator clock, separate from the system clock. A prescaler of `PRESCALE_W` bits divides the oscillator, and each time it wraps it advances a `CNT_W`-bit timeout counter. When the counter wraps past its top value, the block drives a reset pulse of fixed length. That length is `PULSE_UNITS` prescaler periods.

Software controls the block through one 8-bit key register and reads or reloads the counter. Both are reached through a small request port in the system clock domain. A two-flop toggle handshake carries each request into the oscillator domain, and the reply comes back the same way.

The key register uses magic values. One value halts the watchdog and clears it. Any other value lets it count. A second value unlocks a single counter reload, and that reload locks the key again. Software sets the timeout by loading the counter with a start value and then reloading it before it wraps.

Top module: `keyed_watchdog`

## Requirements
- R1: After `sys_rst_n` is released, the key register reads 0xA5, the counter reads 0x00, `wd_reset` is low and the counter does not move.
- R2: While the key register holds any value other than 0xA5, the counter advances by one every 2^PRESCALE_W oscillator cycles.
- R3: Writing 0xA5 to the key register clears the prescaler and the counter and stops counting. The counter then stays at 0x00.
- R4: A counter write is accepted only while the key register holds 0x5A. At any other time it changes neither the counter, the key register nor the prescaler.
- R5: An accepted counter write loads the counter, clears the prescaler and sets the key register to 0x00. Counting continues.
- R6: After a reload with value T, `wd_reset` rises (2^CNT_W − T) × 2^PRESCALE_W oscillator cycles after the reload takes effect.
- R7: `wd_reset` stays high for exactly PULSE_UNITS × 2^PRESCALE_W oscillator cycles.
- R8: While `wd_reset` is high, the key register and the counter are held at 0xA5 and 0x00, and all writes are ignored. The pulse still runs its full length. After the pulse the watchdog is halted.
- R9: Reading the counter returns its present value and does not disturb counting or the timeout.
- R10: A request is taken on a `sys_clk` edge where `bus_req` is high and `bus_busy` is low. `bus_busy` then stays high until a one-cycle `bus_done`, which comes with `bus_busy` low and carries the read value on `bus_rdata`. `bus_sel` = 0 selects the key register and `bus_sel` = 1 selects the counter.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| sys_clk | input | 1 | System clock for the request port |
| sys_rst_n | input | 1 | Active-low asynchronous reset for both domains |
| bus_req | input | 1 | Request strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_sel | input | 1 | 0 = key register, 1 = counter |
| bus_wdata | input | 8 | Write data |
| bus_busy | output | 1 | Request in flight |
| bus_done | output | 1 | One-cycle completion strobe |
| bus_rdata | output | 8 | Read data, valid with `bus_done` |
| wd_clk | input | 1 | Free-running watchdog oscillator clock |
| wd_reset | output | 1 | Active-high watchdog reset pulse (wd_clk domain) |

## Verification
The bench builds the block with PRESCALE_W = 3, CNT_W = 8, PULSE_UNITS = 16 and two synchronizer stages. With these values one counter step takes 8 oscillator cycles and the reset pulse lasts 128 cycles. That makes a full timeout, the complete pulse, and a write landing in the middle of a pulse short enough to measure edge by edge. The default 11-bit prescaler would need tens of thousands of cycles for each of these. The handshake costs three oscillator edges plus at most one edge of phase, so timeouts are checked inside a two-edge window. Pulse lengths are checked exactly.

// File: rtl/wdk_pkg.sv
package wdk_pkg;
   localparam logic [7:0] KEY_HALT = 8'hA5;
   localparam logic [7:0] KEY_OPEN = 8'h5A;
   localparam logic [7:0] KEY_RUN  = 8'h00;

   typedef enum logic {
      SEL_KEY = 1'b0,
      SEL_CNT = 1'b1
   } sel_e;

   typedef struct packed {
      logic       we;
      sel_e       sel;
      logic [7:0] data;
   } cmd_t;
endpackage

// File: rtl/wdk_sync.sv
module wdk_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   logic [STAGES-1:0] chain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '0;
      else        chain_q <= {chain_q[STAGES-2:0], d};
   end

   assign q = chain_q[STAGES-1];

   initial begin
      assert (STAGES >= 2) else $error("wdk_sync: STAGES must be at least 2");
   end
endmodule

// File: rtl/wdk_xfer.sv
module wdk_xfer
   import wdk_pkg::*;
#(
   parameter int SYNC_STAGES = 2
) (
   input  logic       sys_clk,
   input  logic       sys_rst_n,
   input  logic       req,
   input  cmd_t       req_cmd,
   output logic       busy,
   output logic       done,
   output logic [7:0] rdata,
   input  logic       wd_clk,
   input  logic       wd_rst_n,
   output logic       stb,
   output cmd_t       stb_cmd,
   input  logic [7:0] reply
);
   // oscillator-domain state
   logic       req_s, req_seen_q, ack_q;
   logic [7:0] reply_q;
   // system-domain state
   logic       tgl_q, ack_s, ack_seen_q, busy_q, done_q;
   logic [7:0] rdata_q;
   cmd_t       hold_q;
   logic       ack_edge;

   wdk_sync #(.STAGES(SYNC_STAGES)) u_ack_sync (
      .clk(sys_clk), .rst_n(sys_rst_n), .d(ack_q), .q(ack_s));

   assign ack_edge = ack_s ^ ack_seen_q;

   always_ff @(posedge sys_clk or negedge sys_rst_n) begin
      if (!sys_rst_n) begin
         tgl_q      <= 1'b0;
         ack_seen_q <= 1'b0;
         busy_q     <= 1'b0;
         done_q     <= 1'b0;
         rdata_q    <= '0;
         hold_q     <= '0;
      end else begin
         ack_seen_q <= ack_s;
         done_q     <= 1'b0;
         if (busy_q && ack_edge) begin
            busy_q  <= 1'b0;
            done_q  <= 1'b1;
            rdata_q <= reply_q;
         end else if (!busy_q && req) begin
            hold_q <= req_cmd;
            tgl_q  <= ~tgl_q;
            busy_q <= 1'b1;
         end
      end
   end

   wdk_sync #(.STAGES(SYNC_STAGES)) u_req_sync (
      .clk(wd_clk), .rst_n(wd_rst_n), .d(tgl_q), .q(req_s));

   assign stb     = req_s ^ req_seen_q;
   assign stb_cmd = hold_q;

   always_ff @(posedge wd_clk or negedge wd_rst_n) begin
      if (!wd_rst_n) begin
         req_seen_q <= 1'b0;
         ack_q      <= 1'b0;
         reply_q    <= '0;
      end else begin
         req_seen_q <= req_s;
         if (stb) begin
            ack_q   <= ~ack_q;
            reply_q <= reply;
         end
      end
   end

   assign busy  = busy_q;
   assign done  = done_q;
   assign rdata = rdata_q;

   AST_DONE_IDLE: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
      done_q |-> !busy_q); // R10
   AST_BUSY_CAUSE: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
      $rose(busy_q) |-> $past(req)); // R10
   AST_SINGLE_STROBE: assert property (@(posedge wd_clk) disable iff (!wd_rst_n)
      stb |=> !stb); // R10
endmodule

// File: rtl/wdk_core.sv
module wdk_core
   import wdk_pkg::*;
#(
   parameter int PRESCALE_W = 11,
   parameter int CNT_W      = 8
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       hold,
   input  logic       stb,
   input  cmd_t       stb_cmd,
   output logic       ovf,
   output logic [7:0] view
);
   logic [PRESCALE_W-1:0] pre_q;
   logic [CNT_W-1:0]      cnt_q;
   logic [7:0]            key_q, cnt_view;
   logic                  run, pre_full, wr_key, wr_cnt, wipe;

   assign run      = (key_q != KEY_HALT);
   assign pre_full = &pre_q;
   assign wr_key   = stb && stb_cmd.we && (stb_cmd.sel == SEL_KEY) && !hold;
   assign wr_cnt   = stb && stb_cmd.we && (stb_cmd.sel == SEL_CNT) &&
                     (key_q == KEY_OPEN) && !hold;
   assign wipe     = wr_key && (stb_cmd.data == KEY_HALT);
   assign ovf      = run && pre_full && (&cnt_q) && !hold && !wipe && !wr_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pre_q <= '0;
         cnt_q <= '0;
         key_q <= KEY_HALT;
      end else if (hold) begin
         pre_q <= '0;
         cnt_q <= '0;
         key_q <= KEY_HALT;
      end else begin
         if (wr_key)      key_q <= stb_cmd.data;
         else if (wr_cnt) key_q <= KEY_RUN;

         if (wipe) begin
            pre_q <= '0;
            cnt_q <= '0;
         end else if (wr_cnt) begin
            pre_q <= '0;
            cnt_q <= stb_cmd.data[CNT_W-1:0];
         end else if (run) begin
            pre_q <= pre_q + PRESCALE_W'(1);
            if (pre_full) cnt_q <= cnt_q + CNT_W'(1);
         end
      end
   end

   generate
      if (CNT_W == 8) begin : g_full
         assign cnt_view = cnt_q;
      end else begin : g_pad
         assign cnt_view = {{(8-CNT_W){1'b0}}, cnt_q};
      end
   endgenerate

   assign view = (stb_cmd.sel == SEL_KEY) ? key_q : cnt_view;

   AST_HALT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      (key_q == KEY_HALT) |=> $stable(cnt_q)); // R3
   AST_STEP_RATE: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !hold && !stb && !pre_full) |=> $stable(cnt_q)); // R2
   AST_LOCKED_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (stb && stb_cmd.we && stb_cmd.sel == SEL_CNT && key_q != KEY_OPEN && !hold)
      |=> $stable(key_q)); // R4
   AST_RELOCK: assert property (@(posedge clk) disable iff (!rst_n)
      wr_cnt |=> (key_q == KEY_RUN && pre_q == '0)); // R5
   AST_HOLD_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      hold |=> (key_q == KEY_HALT && cnt_q == '0)); // R8
endmodule

// File: rtl/wdk_pulse.sv
module wdk_pulse #(
   parameter int LEN = 32768
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic active
);
   localparam int              LEN_W = $clog2(LEN + 1);
   localparam logic [LEN_W-1:0] LEN_V = LEN_W'(LEN);

   logic [LEN_W-1:0] left_q;
   logic             active_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active_q <= 1'b0;
         left_q   <= '0;
      end else if (active_q) begin
         left_q <= left_q - LEN_W'(1);
         if (left_q == LEN_W'(1)) active_q <= 1'b0;
      end else if (start) begin
         active_q <= 1'b1;
         left_q   <= LEN_V;
      end
   end

   assign active = active_q;

   initial begin
      assert (LEN >= 1) else $error("wdk_pulse: LEN must be at least 1");
   end

   AST_PULSE_FULL: assert property (@(posedge clk) disable iff (!rst_n)
      (active_q && left_q > LEN_W'(1)) |=> active_q); // R7
   AST_PULSE_START: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !active_q) |=> (active_q && left_q == LEN_V)); // R6
endmodule

// File: rtl/keyed_watchdog.sv
module keyed_watchdog
   import wdk_pkg::*;
#(
   parameter int PRESCALE_W  = 11,
   parameter int CNT_W       = 8,
   parameter int PULSE_UNITS = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic       sys_clk,
   input  logic       sys_rst_n,
   input  logic       bus_req,
   input  logic       bus_we,
   input  logic       bus_sel,
   input  logic [7:0] bus_wdata,
   output logic       bus_busy,
   output logic       bus_done,
   output logic [7:0] bus_rdata,
   input  logic       wd_clk,
   output logic       wd_reset
);
   localparam int PULSE_LEN = PULSE_UNITS * (2 ** PRESCALE_W);

   initial begin
      assert (PRESCALE_W >= 1 && PRESCALE_W <= 20)
         else $error("keyed_watchdog: PRESCALE_W out of range");
      assert (CNT_W >= 1 && CNT_W <= 8)
         else $error("keyed_watchdog: CNT_W out of range");
      assert (PULSE_UNITS >= 1)
         else $error("keyed_watchdog: PULSE_UNITS must be positive");
   end

   logic       sys_rst_s, wd_rst_s, stb, ovf, active;
   logic [7:0] view;
   cmd_t       bus_cmd, stb_cmd;

   assign bus_cmd = '{we: bus_we, sel: sel_e'(bus_sel), data: bus_wdata};

   wdk_sync #(.STAGES(SYNC_STAGES)) u_sys_rst (
      .clk(sys_clk), .rst_n(sys_rst_n), .d(1'b1), .q(sys_rst_s));
   wdk_sync #(.STAGES(SYNC_STAGES)) u_wd_rst (
      .clk(wd_clk), .rst_n(sys_rst_n), .d(1'b1), .q(wd_rst_s));

   wdk_xfer #(.SYNC_STAGES(SYNC_STAGES)) u_xfer (
      .sys_clk(sys_clk), .sys_rst_n(sys_rst_s), .req(bus_req), .req_cmd(bus_cmd),
      .busy(bus_busy), .done(bus_done), .rdata(bus_rdata),
      .wd_clk(wd_clk), .wd_rst_n(wd_rst_s), .stb(stb), .stb_cmd(stb_cmd),
      .reply(view));

   wdk_core #(.PRESCALE_W(PRESCALE_W), .CNT_W(CNT_W)) u_core (
      .clk(wd_clk), .rst_n(wd_rst_s), .hold(active), .stb(stb),
      .stb_cmd(stb_cmd), .ovf(ovf), .view(view));

   wdk_pulse #(.LEN(PULSE_LEN)) u_pulse (
      .clk(wd_clk), .rst_n(wd_rst_s), .start(ovf), .active(active));

   assign wd_reset = active;

   AST_PULSE_ON_WRAP: assert property (@(posedge wd_clk) disable iff (!wd_rst_s)
      (ovf && !active) |=> wd_reset); // R6
endmodule

// File: tb/keyed_watchdog_bench.sv
module keyed_watchdog_bench;
   localparam int PW    = 3;
   localparam int CW    = 8;
   localparam int PU    = 16;
   localparam int STEP  = 2 ** PW;
   localparam int PULSE = PU * STEP;
   localparam int NV    = 14;

   // vector: {we, sel, wdata[7:0], chk, exp[7:0], req[3:0]}
   localparam logic [22:0] VEC [NV] = '{
      {1'b0, 1'b0, 8'h00, 1'b1, 8'hA5, 4'd1},  // R1 key after reset
      {1'b0, 1'b1, 8'h00, 1'b1, 8'h00, 4'd1},  // R1 counter after reset
      {1'b1, 1'b1, 8'h40, 1'b0, 8'h00, 4'd4},  // R4 locked counter write
      {1'b0, 1'b1, 8'h00, 1'b1, 8'h00, 4'd4},  // R4 counter unchanged
      {1'b0, 1'b0, 8'h00, 1'b1, 8'hA5, 4'd4},  // R4 key unchanged
      {1'b1, 1'b0, 8'h5A, 1'b0, 8'h00, 4'd4},  // R4 unlock
      {1'b0, 1'b0, 8'h00, 1'b1, 8'h5A, 4'd4},  // R4 key open
      {1'b1, 1'b1, 8'hF0, 1'b0, 8'h00, 4'd5},  // R5 accepted reload
      {1'b0, 1'b1, 8'h00, 1'b1, 8'hF0, 4'd5},  // R5 loaded value
      {1'b0, 1'b0, 8'h00, 1'b1, 8'h00, 4'd5},  // R5 key relocked
      {1'b1, 1'b0, 8'hA5, 1'b0, 8'h00, 4'd3},  // R3 halt
      {1'b1, 1'b1, 8'h22, 1'b0, 8'h00, 4'd4},  // R4 write while halted
      {1'b0, 1'b1, 8'h00, 1'b1, 8'h00, 4'd3},  // R3 cleared counter
      {1'b0, 1'b0, 8'h00, 1'b1, 8'hA5, 4'd3}   // R3 halted key
   };

   logic       sys_clk = 1'b0;
   logic       wd_clk  = 1'b0;
   logic       sys_rst_n = 1'b0;
   logic       bus_req = 1'b0;
   logic       bus_we  = 1'b0;
   logic       bus_sel = 1'b0;
   logic [7:0] bus_wdata = 8'h00;
   logic       bus_busy, bus_done, wd_reset;
   logic [7:0] bus_rdata;

   int compared   = 0;
   int mismatched = 0;
   int wd_edges   = 0;
   int issue_edge = 0;
   bit busy_seen  = 1'b0;

   always #2 sys_clk = ~sys_clk;
   always #7 wd_clk  = ~wd_clk;
   always @(posedge wd_clk) wd_edges <= wd_edges + 1;

   keyed_watchdog #(.PRESCALE_W(PW), .CNT_W(CW), .PULSE_UNITS(PU), .SYNC_STAGES(2))
   u_keyed_watchdog (
      .sys_clk(sys_clk), .sys_rst_n(sys_rst_n), .bus_req(bus_req), .bus_we(bus_we),
      .bus_sel(bus_sel), .bus_wdata(bus_wdata), .bus_busy(bus_busy),
      .bus_done(bus_done), .bus_rdata(bus_rdata), .wd_clk(wd_clk), .wd_reset(wd_reset));

   task automatic check(input string tag, input int act, input int exp);
      compared++;
      if (act != exp) begin
         mismatched++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
      end
   endtask

   task automatic check_win(input string tag, input int act, input int lo, input int hi);
      compared++;
      if (act < lo || act > hi) begin
         mismatched++;
         $display("FAIL %s: actual %0d expected %0d..%0d", tag, act, lo, hi);
      end
   endtask

   task automatic bus_op(input logic we, input logic sel, input logic [7:0] data,
                         output logic [7:0] rd);
      @(negedge sys_clk);
      bus_req = 1'b1; bus_we = we; bus_sel = sel; bus_wdata = data;
      issue_edge = wd_edges;
      @(negedge sys_clk);
      bus_req = 1'b0;
      busy_seen = bus_busy;
      for (int i = 0; i < 200 && !bus_done; i++) @(negedge sys_clk);
      if (!bus_done) check("R10 completion", 0, 1);
      rd = bus_rdata;
   endtask

   task automatic wait_reset(input logic lvl, input int limit, output int at, output bit ok);
      ok = 1'b0;
      at = 0;
      for (int i = 0; i < limit; i++) begin
         @(negedge wd_clk);
         if (wd_reset == lvl) begin
            ok = 1'b1;
            at = wd_edges;
            break;
         end
      end
   endtask

   initial begin
      repeat (150000) @(posedge sys_clk);
      compared++;
      mismatched++;
      $display("FAIL watchdog R10: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end

   initial begin
      logic [7:0]  rd;
      logic [22:0] v;
      int          t0, r, f;
      bit          ok;

      repeat (5) @(negedge sys_clk);
      sys_rst_n = 1'b1;
      repeat (10) @(negedge wd_clk);
      check("R1 wd_reset low after reset", int'(wd_reset), 0);
      check("R10 idle after reset", int'(bus_busy), 0);

      for (int k = 0; k < NV; k++) begin
         v = VEC[k];
         bus_op(v[22], v[21], v[20:13], rd);
         if (v[12]) check($sformatf("R%0d vector %0d", v[3:0], k), int'(rd), int'(v[11:4]));
      end
      check("R10 busy during request", int'(busy_seen), 1);

      // R6 timeout after reload, R9 read while running, R4 locked write mid-run
      bus_op(1'b1, 1'b0, 8'h5A, rd);
      bus_op(1'b1, 1'b1, 8'hF8, rd);
      t0 = issue_edge;
      bus_op(1'b0, 1'b1, 8'h00, rd);
      check("R9 counter read while running", int'(rd), 8'hF8);
      bus_op(1'b1, 1'b1, 8'h00, rd);
      wait_reset(1'b1, 2000, r, ok);
      check("R6 reset pulse appeared", int'(ok), 1);
      check_win("R6 timeout length (R4 R9 no disturbance)", r - t0,
                (256 - 8'hF8) * STEP + 3, (256 - 8'hF8) * STEP + 4);
      wait_reset(1'b0, 2000, f, ok);
      check("R7 pulse length", f - r, PULSE);

      // R8 writes during the pulse
      bus_op(1'b1, 1'b0, 8'h5A, rd);
      bus_op(1'b1, 1'b1, 8'hFE, rd);
      wait_reset(1'b1, 2000, r, ok);
      check("R8 second pulse appeared", int'(ok), 1);
      bus_op(1'b1, 1'b0, 8'h5A, rd);
      bus_op(1'b1, 1'b1, 8'h80, rd);
      bus_op(1'b0, 1'b0, 8'h00, rd);
      check("R8 key held during pulse", int'(rd), 8'hA5);
      wait_reset(1'b0, 2000, f, ok);
      check("R8 pulse kept full length", f - r, PULSE);
      bus_op(1'b0, 1'b0, 8'h00, rd);
      check("R8 halted after pulse", int'(rd), 8'hA5);
      bus_op(1'b0, 1'b1, 8'h00, rd);
      check("R8 counter cleared after pulse", int'(rd), 8'h00);

      // R2 counting rate with a plain enable value
      bus_op(1'b1, 1'b0, 8'h11, rd);
      t0 = issue_edge;
      while (wd_edges < t0 + 80 + 3) @(negedge wd_clk);
      bus_op(1'b0, 1'b1, 8'h00, rd);
      check_win("R2 counter after 80 cycles", int'(rd), 9, 11);

      // R3 halt clears and freezes
      bus_op(1'b1, 1'b0, 8'hA5, rd);
      bus_op(1'b0, 1'b1, 8'h00, rd);
      check("R3 counter cleared by halt", int'(rd), 8'h00);
      repeat (40) @(negedge wd_clk);
      bus_op(1'b0, 1'b1, 8'h00, rd);
      check("R3 counter frozen while halted", int'(rd), 8'h00);
      check("R3 no reset while halted", int'(wd_reset), 0);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end
endmodule